// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register File

This block is the register file that sits between a simple memory-mapped register bus and a bank of up to sixteen DMA channel engines. It holds global burst settings, a freeze bit and a reset request per channel, sticky completion and error flags with per-channel interrupt enables, and it drives one interrupt line per channel. The channel engines report completion, termination and bus-error events on single-cycle strobes, and each channel presents a 4-bit state code that software can read back.

Every writable register can be written in three ways. A write to its base offset replaces the contents. A write to base plus 0x4 ORs the written ones in. A write to base plus 0x8 clears the bits written as one. Software acknowledges an interrupt by clearing its flag through the clear alias. A hardware event always beats a software clear of the same flag in the same cycle.

A per-channel reset request goes through a small three-state machine. RST_IDLE waits for a request. On a request it moves to RST_FIRE, or to RST_HOLD if the channel reports the flush code 0x8. RST_HOLD returns to RST_IDLE if software withdraws the request, and moves to RST_FIRE once the channel leaves the flush code. RST_FIRE drives a one-cycle reset pulse, clears the request bit and returns to RST_IDLE.

Top module: `dmareg_top`

## Requirements
- R1: After reset every register reads 0 and every output (freeze, reset pulse, interrupt, burst enables) is 0.
- R2: Accesses use bus_addr[3:2] to pick the write kind: 00 writes the whole register, 01 ORs the data in, 10 clears the bits written as 1, and 11 writes nothing. Reads at offsets +0x0, +0x4 and +0x8 return the base register, and a read at +0xC returns 0. Register bits for channels at or above the channel count read 0.
- R3: The global register at 0x000 holds only bit 28 (burst enable, driven on burst_en) and bit 29 (8-beat burst enable, driven on burst8_en). All other bits read 0.
- R4: In the control register at 0x030, bit n is channel n's freeze bit and drives chan_freeze[n].
- R5: In the completion register at 0x010, bit n is a sticky flag that evt_done[n] sets. Bit 16+n is channel n's completion interrupt enable.
- R6: In the error register at 0x020, bit n is a sticky error flag that evt_term[n] or evt_buserr[n] sets. Bit 16+n records the cause: 0 for a termination and 1 for a bus error. A bus error wins if both events arrive in the same cycle.
- R7: If an event and a software clear of the same flag arrive in the same cycle, the flag stays set.
- R8: chan_irq[n] is (completion flag n AND enable n) OR error flag n, with no added cycle of delay.
- R9: Setting bit 16+n of 0x030 while channel n's state is not 0x8 gives chan_reset[n] high for exactly one cycle, starting one cycle after the request bit reads 1. The request bit reads 0 from the cycle after the pulse.
- R10: While channel n's state is 0x8, a reset request stays pending with no pulse. The pulse follows one cycle after the state changes. Clearing the request while it is pending cancels it.
- R11: The address 0x100 + n*0x70 reads channel n's state code in bits 3:0. Writes to that address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; bits 1:0 must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| evt_done | input | NCH | Per-channel completion strobe |
| evt_term | input | NCH | Per-channel termination-error strobe |
| evt_buserr | input | NCH | Per-channel bus-error strobe |
| chan_state | input | NCH*STW | Per-channel state codes, channel n at [n*STW +: STW] |
| chan_freeze | output | NCH | Per-channel freeze (stall) |
| chan_reset | output | NCH | Per-channel one-cycle reset pulse |
| chan_irq | output | NCH | Per-channel interrupt |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |

## Verification
The bench builds the block with NCH = 4 and the other parameters at their defaults. With four channels, a four-bit channel field has only 16 values, so the bench can sweep every old value against every written mask for all three write kinds. It also sweeps every enable pattern against the interrupt outputs. The reduced channel count also leaves bits 15:4 and 31:20 unimplemented, so the bench can check that those bits read 0. The reset-request machine is driven through all of its transitions: immediate fire, a hold while the flush code is present, and a withdrawal during the hold.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    // Write kind, selected by bus_addr[3:2]
    typedef enum logic [1:0] {
        WR_DIRECT = 2'b00,
        WR_SET    = 2'b01,
        WR_CLEAR  = 2'b10,
        WR_NONE   = 2'b11
    } wr_kind_e;

    // Per-channel reset request sequencing
    typedef enum logic [1:0] {
        RST_IDLE = 2'b00,
        RST_HOLD = 2'b01,
        RST_FIRE = 2'b10
    } rst_state_e;

    // State code that marks a channel flushing after a read
    localparam logic [3:0] FLUSH_CODE = 4'h8;

endpackage

// File: rtl/dmareg_wrdec.sv
module dmareg_wrdec
    import dmareg_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NREG = 4
) (
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    output wr_kind_e        kind_o,
    output logic [NREG-1:0] hit_o
);
    localparam int IW = AW - 4;

    always_comb begin
        kind_o = wr_kind_e'(bus_addr[3:2]);
        hit_o  = '0;
        for (int i = 0; i < NREG; i++) begin
            hit_o[i] = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00)
                       && (bus_addr[AW-1:4] == IW'(i))
                       && (kind_o != WR_NONE);
        end
    end
endmodule

// File: rtl/dmareg_field.sv
module dmareg_field
    import dmareg_pkg::*;
#(
    parameter int W = 16
) (
    input  wr_kind_e      kind_i,
    input  logic [W-1:0]  cur_i,
    input  logic [W-1:0]  wd_i,
    output logic [W-1:0]  nxt_o
);
    always_comb begin
        unique case (kind_i)
            WR_DIRECT: nxt_o = wd_i;
            WR_SET:    nxt_o = cur_i | wd_i;
            WR_CLEAR:  nxt_o = cur_i & ~wd_i;
            WR_NONE:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/dmareg_chan_rst.sv
module dmareg_chan_rst
    import dmareg_pkg::*;
#(
    parameter int STW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [STW-1:0] state_i,
    output logic           fire_o
);
    localparam logic [STW-1:0] FLUSH = STW'(FLUSH_CODE);

    rst_state_e cur, nxt;
    logic       in_flush;

    assign in_flush = (state_i == FLUSH);

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= RST_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            RST_IDLE: if (req_i) nxt = in_flush ? RST_HOLD : RST_FIRE;
            RST_HOLD: begin
                if (!req_i)         nxt = RST_IDLE;
                else if (!in_flush) nxt = RST_FIRE;
            end
            RST_FIRE: nxt = RST_IDLE;
            default:  nxt = RST_IDLE;
        endcase
    end

    always_comb begin
        fire_o = (cur == RST_FIRE);
    end

    // R9: reset pulse lasts exactly one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R10: pulse is only issued after a cycle outside the flush code
    assert_no_fire_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ($past(state_i) != FLUSH));

    // R10: a held request does not fire while flush persists
    assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == RST_HOLD && in_flush) |=> !fire_o);
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int AW        = 12,
    parameter int STW       = 4,
    parameter int CH_BASE   = 'h100,
    parameter int CH_STRIDE = 'h70
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NCH-1:0]     evt_done,
    input  logic [NCH-1:0]     evt_term,
    input  logic [NCH-1:0]     evt_buserr,
    input  logic [NCH*STW-1:0] chan_state,
    output logic [NCH-1:0]     chan_freeze,
    output logic [NCH-1:0]     chan_reset,
    output logic [NCH-1:0]     chan_irq,
    output logic               burst_en,
    output logic               burst8_en
);
    localparam int IW       = AW - 4;
    localparam int NREG     = 4;
    localparam int REG_GLB  = 0;
    localparam int REG_DONE = 1;
    localparam int REG_ERR  = 2;
    localparam int REG_CTL  = 3;
    localparam int HI       = 16;
    localparam int BURST_LSB = 28;

    // Register state
    logic [1:0]     burst_q;
    logic [NCH-1:0] done_q, den_q, err_q, cause_q, frz_q, rreq_q;
    logic [NCH-1:0] fire;

    // Write decode
    wr_kind_e       kind;
    logic [NREG-1:0] hit;
    wr_kind_e       k_glb, k_done, k_err, k_ctl;

    dmareg_wrdec #(.AW(AW), .NREG(NREG)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .kind_o  (kind),
        .hit_o   (hit)
    );

    assign k_glb  = hit[REG_GLB]  ? kind : WR_NONE;
    assign k_done = hit[REG_DONE] ? kind : WR_NONE;
    assign k_err  = hit[REG_ERR]  ? kind : WR_NONE;
    assign k_ctl  = hit[REG_CTL]  ? kind : WR_NONE;

    // Software-updated field values
    logic [1:0]     burst_n;
    logic [NCH-1:0] done_n, den_n, err_n, cause_n, frz_n, rreq_n;

    dmareg_field #(.W(2)) u_f_burst (
        .kind_i(k_glb), .cur_i(burst_q), .wd_i(bus_wdata[BURST_LSB +: 2]), .nxt_o(burst_n));
    dmareg_field #(.W(NCH)) u_f_done (
        .kind_i(k_done), .cur_i(done_q), .wd_i(bus_wdata[NCH-1:0]), .nxt_o(done_n));
    dmareg_field #(.W(NCH)) u_f_den (
        .kind_i(k_done), .cur_i(den_q), .wd_i(bus_wdata[HI +: NCH]), .nxt_o(den_n));
    dmareg_field #(.W(NCH)) u_f_err (
        .kind_i(k_err), .cur_i(err_q), .wd_i(bus_wdata[NCH-1:0]), .nxt_o(err_n));
    dmareg_field #(.W(NCH)) u_f_cause (
        .kind_i(k_err), .cur_i(cause_q), .wd_i(bus_wdata[HI +: NCH]), .nxt_o(cause_n));
    dmareg_field #(.W(NCH)) u_f_frz (
        .kind_i(k_ctl), .cur_i(frz_q), .wd_i(bus_wdata[NCH-1:0]), .nxt_o(frz_n));
    dmareg_field #(.W(NCH)) u_f_rreq (
        .kind_i(k_ctl), .cur_i(rreq_q), .wd_i(bus_wdata[HI +: NCH]), .nxt_o(rreq_n));

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // Register update: events override software clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= '0;
            done_q  <= '0;
            den_q   <= '0;
            err_q   <= '0;
            cause_q <= '0;
            frz_q   <= '0;
            rreq_q  <= '0;
        end else begin
            burst_q <= burst_n;
            done_q  <= done_n | evt_done;
            den_q   <= den_n;
            err_q   <= err_n | evt_term | evt_buserr;
            cause_q <= (cause_n & ~(evt_term | evt_buserr)) | evt_buserr;
            frz_q   <= frz_n;
            rreq_q  <= rreq_n & ~fire;
        end
    end

    // Per-channel reset sequencers
    for (genvar n = 0; n < NCH; n++) begin : g_rst
        dmareg_chan_rst #(.STW(STW)) u_rst (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (rreq_q[n]),
            .state_i(chan_state[n*STW +: STW]),
            .fire_o (fire[n])
        );
    end

    // Outputs
    assign chan_freeze = frz_q;
    assign chan_reset  = fire;
    assign chan_irq    = (done_q & den_q) | err_q;
    assign burst_en    = burst_q[0];
    assign burst8_en   = burst_q[1];

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[3:2] != 2'b11) begin
            case (bus_addr[AW-1:4])
                IW'(REG_GLB):  bus_rdata[BURST_LSB +: 2] = burst_q;
                IW'(REG_DONE): begin
                    bus_rdata[NCH-1:0]  = done_q;
                    bus_rdata[HI +: NCH] = den_q;
                end
                IW'(REG_ERR): begin
                    bus_rdata[NCH-1:0]  = err_q;
                    bus_rdata[HI +: NCH] = cause_q;
                end
                IW'(REG_CTL): begin
                    bus_rdata[NCH-1:0]  = frz_q;
                    bus_rdata[HI +: NCH] = rreq_q;
                end
                default: ;
            endcase
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr[AW-1:4] == IW'((CH_BASE + n * CH_STRIDE) >> 4))
                    bus_rdata[STW-1:0] = chan_state[n*STW +: STW];
            end
        end
    end

    // Per-channel properties
    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R5 / R7: a completion event always leaves the flag set
        assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            evt_done[n] |=> done_q[n]);
        // R6: a bus error sets the flag and a cause of 1
        assert_buserr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_buserr[n] |=> (err_q[n] && cause_q[n]));
        // R6: a lone termination sets the flag and a cause of 0
        assert_term_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_term[n] && !evt_buserr[n]) |=> (err_q[n] && !cause_q[n]));
        // R9: the request bit drops after the pulse
        assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fire[n] |=> !rreq_q[n]);
    end
endmodule

// File: tb/dmareg_top_test.sv
`timescale 1ns/1ps
module dmareg_top_test;
    localparam int NCH = 4;
    localparam int STW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    evt_done = '0, evt_term = '0, evt_buserr = '0;
    logic [NCH*STW-1:0] chan_state = '0;
    logic [NCH-1:0]    chan_freeze, chan_reset, chan_irq;
    logic              burst_en, burst8_en;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses [NCH];

    always #4 clk = ~clk;

    dmareg_top #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_done(evt_done), .evt_term(evt_term), .evt_buserr(evt_buserr),
        .chan_state(chan_state), .chan_freeze(chan_freeze), .chan_reset(chan_reset),
        .chan_irq(chan_irq), .burst_en(burst_en), .burst8_en(burst8_en)
    );

    initial for (int i = 0; i < NCH; i++) pulses[i] = 0;
    always @(posedge clk) if (rst_n) for (int i = 0; i < NCH; i++) pulses[i] += int'(chan_reset[i]);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] tm, input logic [NCH-1:0] be);
        @(negedge clk);
        evt_done = dn; evt_term = tm; evt_buserr = be;
        @(negedge clk);
        evt_done = '0; evt_term = '0; evt_buserr = '0;
    endtask

    logic [31:0] d, e;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(12'(a * 16), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 outputs after reset", {chan_freeze, chan_reset, chan_irq, 2'b00, burst_en, burst8_en},
            32'h0);

        // R3: global burst bits
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); chk("R3 global write all", d, 32'h3000_0000);
        chk("R3 burst outputs", {30'h0, burst8_en, burst_en}, 32'h3);
        wr(12'h008, 32'h1000_0000);
        rd(12'h000, d); chk("R3 clear burst", d, 32'h2000_0000);
        chk("R3 burst outputs after clear", {30'h0, burst8_en, burst_en}, 32'h2);

        // R2 / R4: exhaustive freeze-field sweep over old value, mask and write kind
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                for (int op = 0; op < 3; op++) begin
                    wr(12'h030, 32'(p));
                    wr(12'(12'h030 + 4 * op), 32'(m));
                    case (op)
                        0: e = 32'(m);
                        1: e = 32'(p | m);
                        default: e = 32'(p & ~m);
                    endcase
                    rd(12'(12'h030 + 4 * op), d);
                    chk($sformatf("R2 op%0d p=%0d m=%0d", op, p, m), d, e);
                    chk($sformatf("R4 freeze op%0d p=%0d m=%0d", op, p, m), 32'(chan_freeze), e);
                end
            end
        end
        wr(12'h030, 32'h0);
        wr(12'h03C, 32'hF);
        rd(12'h030, d); chk("R2 kind 11 writes nothing", d, 32'h0);
        rd(12'h03C, d); chk("R2 +C reads zero", d, 32'h0);

        // R2: unimplemented channel bits read 0
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, d); chk("R2 unimplemented bits", d, 32'h000F_000F);

        // R5 / R8: done flags with every enable pattern
        wr(12'h010, 32'h0);
        pulse_evt(4'hF, 4'h0, 4'h0);
        rd(12'h010, d); chk("R5 done sticky", d, 32'h0000_000F);
        for (int m = 0; m < 16; m++) begin
            wr(12'h010, 32'(m << 16) | 32'hF);
            rd(12'h010, d); chk($sformatf("R5 enables m=%0d", m), d, 32'(m << 16) | 32'hF);
            chk($sformatf("R8 irq m=%0d", m), 32'(chan_irq), 32'(m));
        end
        wr(12'h018, 32'h5);
        chk("R8 irq after ack", 32'(chan_irq), 32'hA);
        wr(12'h010, 32'h0);

        // R7: event beats a same-cycle clear
        wr(12'h014, 32'h2);
        @(negedge clk);
        evt_done = 4'h2; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h2;
        @(negedge clk);
        evt_done = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h010, d); chk("R7 done event vs clear", d, 32'h2);
        wr(12'h018, 32'h2);
        rd(12'h010, d); chk("R7 clear without event", d, 32'h0);

        // R6 / R8: error flags and causes
        pulse_evt(4'h0, 4'h4, 4'h0);
        rd(12'h020, d); chk("R6 termination cause 0", d, 32'h0000_0004);
        chk("R8 error irq without enable", 32'(chan_irq), 32'h4);
        pulse_evt(4'h0, 4'h0, 4'h8);
        rd(12'h020, d); chk("R6 bus error cause 1", d, 32'h0008_000C);
        pulse_evt(4'h0, 4'h1, 4'h1);
        rd(12'h020, d); chk("R6 bus error wins", d, 32'h0009_000D);
        wr(12'h028, 32'hF);
        rd(12'h024, d); chk("R6 flags acked causes kept", d, 32'h0009_0000);
        chk("R8 irq cleared", 32'(chan_irq), 32'h0);
        pulse_evt(4'h0, 4'h8, 4'h0);
        rd(12'h020, d); chk("R6 termination clears cause", d, 32'h0001_0008);
        @(negedge clk);
        evt_term = 4'h8; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h028; bus_wdata = 32'h8;
        @(negedge clk);
        evt_term = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h020, d); chk("R7 error event vs clear", d, 32'h0001_0008);
        wr(12'h020, 32'h0);

        // R9: immediate reset pulse
        wr(12'h034, 32'h0001_0000);
        chk("R9 no pulse yet", 32'(chan_reset), 32'h0);
        rd(12'h030, d); chk("R9 request pending", d, 32'h0001_0000);
        chk("R9 pulse", 32'(chan_reset), 32'h1);
        @(negedge clk);
        chk("R9 pulse ends", 32'(chan_reset), 32'h0);
        rd(12'h030, d); chk("R9 request self-clears", d, 32'h0);
        chk("R9 pulse count", 32'(pulses[0]), 32'd1);

        // R10: hold during flush
        chan_state[2*STW +: STW] = 4'h8;
        wr(12'h034, 32'h0004_0000);
        repeat (10) begin
            @(negedge clk);
            if (chan_reset !== 4'h0) chk("R10 no pulse in flush", 32'(chan_reset), 32'h0);
        end
        rd(12'h030, d); chk("R10 request held", d, 32'h0004_0000);
        chk("R10 no pulse counted", 32'(pulses[2]), 32'd0);
        chan_state[2*STW +: STW] = 4'h3;
        @(negedge clk);
        chk("R10 pulse after leaving flush", 32'(chan_reset), 32'h4);
        @(negedge clk);
        rd(12'h030, d); chk("R10 request cleared", d, 32'h0);
        chk("R10 single pulse", 32'(pulses[2]), 32'd1);

        // R10: cancel while held
        chan_state[1*STW +: STW] = 4'h8;
        wr(12'h034, 32'h0002_0000);
        repeat (3) @(negedge clk);
        wr(12'h038, 32'h0002_0000);
        repeat (2) @(negedge clk);
        chan_state[1*STW +: STW] = 4'h0;
        repeat (5) @(negedge clk);
        chk("R10 cancelled request no pulse", 32'(pulses[1]), 32'd0);
        rd(12'h030, d); chk("R10 cancelled request reads 0", d, 32'h0);

        // R11: state readback at stride 0x70
        for (int n = 0; n < NCH; n++) chan_state[n*STW +: STW] = 4'(3 * n + 1);
        for (int n = 0; n < NCH; n++) begin
            rd(12'(12'h100 + n * 12'h70), d);
            chk($sformatf("R11 state ch%0d", n), d, 32'(3 * n + 1));
        end
        wr(12'h030, 32'h0000_0005);
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, d); chk("R11 status write ignored", d, 32'h1);
        rd(12'h030, d); chk("R11 control untouched", d, 32'h0000_0005);
        chk("R11 reset untouched", 32'(pulses[0]), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule